// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request source and an external asynchronous static RAM. The RAM holds 256K words of 16 bits, reached through an 18-bit word address. Its data bus is split into a lower byte (bits 7:0) and an upper byte (bits 15:8), and each byte has its own active-low select strobe. The controller takes one request at a time over a valid/ready handshake. Each request carries an address, write data, a read/write flag and two byte-enable bits. The controller turns it into a timed sequence on the active-low chip select, output enable, write enable and the two byte strobes.

Every phase length is derived from a nanosecond limit and the clock period parameter. Each length is the ceiling of the limit divided by the period, and never less than one cycle. A write has a setup cycle with chip select low and write enable high, then a write-enable-low pulse, then a hold cycle. Address and data stay fixed over all three. A read holds chip select and output enable low for the access time. The data is captured in the last access cycle, and byte lanes that were not enabled are returned as zero. The controller drives its data pins only during write phases. When the direction changes between requests, it inserts idle cycles that cover the memory's release time, so the two drivers never overlap.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, chip select, output enable, write enable and both byte strobes are high, the data-pin enable is low, `req_ready` is high and `rsp_done` is low.
- R2: A write asserts chip select (low) one cycle before write enable falls. Write enable stays low for WP cycles, where WP = max(ceil(8/T), ceil(6/T), ceil(12/T)-2, 1) and T is `CLK_NS`. Chip select stays low for one cycle after write enable rises.
- R3: While write enable is low, chip select is low and `sram_addr` and `sram_dq_o` do not change.
- R4: While chip select is low, `sram_be_n[0]` (lower byte, data bits 7:0) equals the inverse of request enable bit 0, and `sram_be_n[1]` (upper byte, bits 15:8) equals the inverse of bit 1. A write with both enables clear leaves memory unchanged. Both strobes are high while chip select is high.
- R5: A read holds chip select and output enable low, with write enable high, for RD = max(ceil(12/T), 1) cycles. Memory data is captured at the end of the last of those cycles.
- R6: In returned read data, each byte lane whose enable bit was clear reads as zero. Enabled lanes carry the memory contents.
- R7: Every accepted request produces exactly one `rsp_done` pulse, one cycle wide, after its memory sequence ends. `rsp_rdata` is valid in that cycle.
- R8: `sram_dq_oe` is high only during the three write phases, and never while output enable is low.
- R9: When a read follows a write or a write follows a read, chip select stays high for at least HZ+1 cycles between the two sequences, where HZ = max(ceil(6/T), 1).
- R10: `req_ready` is high only while no sequence is in progress, and `sram_addr` changes only in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 lower lane, bit 1 upper lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Byte strobes, active low, bit 0 lower, bit 1 upper |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Enable for the data-pin drivers |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
The hardest case to reach from the ports is the direction turnaround at minimum spacing. The idle cycles matter only when a request of the other kind is already waiting the moment the controller goes idle. The driver therefore raises the next request while the previous sequence is still running, so it is taken on the first idle cycle. It then alternates reads and writes to the same addresses. The memory model times how long chip select stays high at every change of direction, and it flags any cycle where both sides drive the bus. Byte masking is covered by partial writes followed by reads with each enable pattern. The model puts a filler value on lanes that are not selected, so any leak into the returned data shows up.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TURN = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WHLD = 3'd4,
    ST_RACC = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_reg.sv
module sram_strobe_reg
  import sram_lane_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_d,
  input  logic [LANES-1:0] be_d,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             drv,
  output logic [LANES-1:0] lane_n
);

  logic             cs_n_d, oe_n_d, we_n_d, drv_d;
  logic [LANES-1:0] lane_n_d;

  // decode of the phase being entered; registered so the pins cannot glitch
  always_comb begin
    cs_n_d   = 1'b1;
    oe_n_d   = 1'b1;
    we_n_d   = 1'b1;
    drv_d    = 1'b0;
    lane_n_d = '1;
    unique case (phase_d)
      ST_WSET, ST_WHLD: begin
        cs_n_d   = 1'b0;
        drv_d    = 1'b1;
        lane_n_d = ~be_d;
      end
      ST_WPUL: begin
        cs_n_d   = 1'b0;
        we_n_d   = 1'b0;
        drv_d    = 1'b1;
        lane_n_d = ~be_d;
      end
      ST_RACC: begin
        cs_n_d   = 1'b0;
        oe_n_d   = 1'b0;
        lane_n_d = ~be_d;
      end
      default: begin
        cs_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      oe_n   <= 1'b1;
      we_n   <= 1'b1;
      drv    <= 1'b0;
      lane_n <= '1;
    end else begin
      cs_n   <= cs_n_d;
      oe_n   <= oe_n_d;
      we_n   <= we_n_d;
      drv    <= drv_d;
      lane_n <= lane_n_d;
    end
  end

  // R8
  drv_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> oe_n);

  // R3
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && oe_n));

  // R4
  lanes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (&lane_n));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [LANES-1:0]        be,
  input  logic [LANES*BYTE_W-1:0] dq_i,
  output logic [LANES*BYTE_W-1:0] rdata
);

  logic [LANES*BYTE_W-1:0] rdata_d;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_d[g*BYTE_W +: BYTE_W] = be[g] ? dq_i[g*BYTE_W +: BYTE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 18,
  parameter int BYTE_W  = 8,
  parameter int T_WC_NS = 12,
  parameter int T_WP_NS = 8,
  parameter int T_DW_NS = 6,
  parameter int T_RC_NS = 12,
  parameter int T_AA_NS = 12,
  parameter int T_HZ_NS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*BYTE_W-1:0]   req_wdata,
  input  logic [1:0]            req_be,
  output logic                  rsp_done,
  output logic [2*BYTE_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_cs_n,
  output logic                  sram_oe_n,
  output logic                  sram_we_n,
  output logic [1:0]            sram_be_n,
  output logic [2*BYTE_W-1:0]   sram_dq_o,
  output logic                  sram_dq_oe,
  input  logic [2*BYTE_W-1:0]   sram_dq_i
);

  localparam int LANES   = 2;
  localparam int DATA_W  = LANES * BYTE_W;
  // setup and hold cycles add two to the write sequence
  localparam int WP_CYC  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                ns_to_cyc(T_WC_NS, CLK_NS) - 2);
  localparam int RD_CYC  = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int CNT_MAX = imax(imax(WP_CYC, RD_CYC), HZ_CYC);
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
  localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_ns = rst_pipe[1];

  phase_e              phase_q, phase_d;
  op_e                 last_op_q, req_op;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    be_q, be_d;
  logic                wr_q;
  logic                done_q, done_d;
  logic                accept, turn_needed;
  logic                cnt_load, cnt_dec, cnt_zero, cap_en;
  logic [CNT_W-1:0]    cnt_val;

  assign req_ready   = (phase_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign req_op      = req_write ? OP_WRITE : OP_READ;
  assign turn_needed = (last_op_q != OP_NONE) && (last_op_q != req_op);
  assign be_d        = accept ? req_be : be_q;

  // request capture
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      wr_q      <= 1'b0;
      last_op_q <= OP_NONE;
    end else if (accept) begin
      addr_q    <= req_addr;
      wdata_q   <= req_wdata;
      be_q      <= req_be;
      wr_q      <= req_write;
      last_op_q <= req_op;
    end
  end

  // sequencer next state
  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cap_en   = 1'b0;
    done_d   = 1'b0;
    unique case (phase_q)
      ST_IDLE: begin
        if (accept) begin
          if (turn_needed) begin
            phase_d  = ST_TURN;
            cnt_load = 1'b1;
            cnt_val  = HZ_LD;
          end else if (req_write) begin
            phase_d  = ST_WSET;
          end else begin
            phase_d  = ST_RACC;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      ST_TURN: begin
        if (cnt_zero) begin
          if (wr_q) begin
            phase_d  = ST_WSET;
          end else begin
            phase_d  = ST_RACC;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      ST_WSET: begin
        phase_d  = ST_WPUL;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      ST_WPUL: begin
        if (cnt_zero) phase_d = ST_WHLD;
      end
      ST_WHLD: begin
        phase_d = ST_IDLE;
        done_d  = 1'b1;
      end
      ST_RACC: begin
        if (cnt_zero) begin
          phase_d = ST_IDLE;
          cap_en  = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: phase_d = ST_IDLE;
    endcase
  end

  assign cnt_dec = !cnt_load &&
                   ((phase_q == ST_TURN) || (phase_q == ST_WPUL) || (phase_q == ST_RACC));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      phase_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  sram_phase_cnt #(
    .CNT_W (CNT_W)
  ) cnt_i (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  sram_strobe_reg #(
    .LANES (LANES)
  ) strobe_i (
    .clk     (clk),
    .rst_n   (rst_ns),
    .phase_d (phase_d),
    .be_d    (be_d),
    .cs_n    (sram_cs_n),
    .oe_n    (sram_oe_n),
    .we_n    (sram_we_n),
    .drv     (sram_dq_oe),
    .lane_n  (sram_be_n)
  );

  sram_rd_capture #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) cap_i (
    .clk    (clk),
    .rst_n  (rst_ns),
    .cap_en (cap_en),
    .be     (be_q),
    .dq_i   (sram_dq_i),
    .rdata  (rsp_rdata)
  );

  assign sram_addr = addr_q;
  assign sram_dq_o = wdata_q;
  assign rsp_done  = done_q;

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !sram_we_n |-> $stable(sram_addr));

  // R3
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !sram_we_n |-> $stable(sram_dq_o));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_done |=> !rsp_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rsp_done |-> (req_ready && sram_cs_n));

  // R10
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !req_ready |=> $stable(sram_addr));

endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int CLK_PERIOD_NS = 10;
  localparam int WP_EXP = 1;   // max(ceil(8/10), ceil(6/10), ceil(12/10)-2, 1)
  localparam int RD_EXP = 2;   // ceil(12/10)
  localparam int HZ_EXP = 1;   // ceil(6/10)

  typedef struct {
    bit          wr;
    logic [1:0]  be;
    logic [15:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_cs_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_be_n;
  logic [15:0] sram_dq_o;
  logic [15:0] model_dq;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    finished = 1'b0;
  item_t sb_q[$];
  logic [15:0] ref_mem [int];
  logic [15:0] mdl_mem [int];

  always #(CLK_PERIOD_NS/2) clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_PERIOD_NS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(model_dq)
  );

  function automatic logic [15:0] init_word(input logic [17:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: issues one request and records what should come back
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    item_t it;
    logic [15:0] cur;
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
    it.wr = wr; it.be = be;
    if (wr) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
      it.exp = 16'h0;
    end else begin
      it.exp = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
    end
    sb_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory model and monitor, sampled mid-cycle
  int   we_run = 0, oe_run = 0, cs_hi_run = 0, last_kind = 0;
  bit   p_we_low = 0, p_oe_low = 0, p_cs_low = 0, p_done = 0;
  logic [17:0] p_addr;
  logic [15:0] p_dq;

  always @(negedge clk) begin
    logic [15:0] w;
    item_t it;
    int kind;
    if (mon_on) begin
      w = mdl_mem.exists(int'(sram_addr)) ? mdl_mem[int'(sram_addr)] : init_word(sram_addr);
      // R8: no driver overlap, drive only in write phases
      if (sram_dq_oe) chk(sram_oe_n && !sram_cs_n, "R8 drive window", {sram_oe_n, sram_cs_n}, 2'b10);
      // R10
      if (!sram_cs_n) chk(!req_ready, "R10 ready while busy", req_ready, 0);
      // R4
      if (!sram_cs_n && sb_q.size() > 0)
        chk(sram_be_n == ~sb_q[0].be, "R4 byte strobes", sram_be_n, ~sb_q[0].be);
      if (sram_cs_n) chk(sram_be_n == 2'b11, "R4 strobes idle", sram_be_n, 2'b11);
      // R2 / R3 write pulse
      if (!sram_we_n) begin
        chk(!sram_cs_n, "R3 cs during write", sram_cs_n, 0);
        if (!p_we_low) chk(p_cs_low, "R2 setup cycle", p_cs_low, 1);
        else begin
          chk(sram_addr == p_addr, "R3 address held", sram_addr, p_addr);
          chk(sram_dq_o == p_dq, "R3 data held", sram_dq_o, p_dq);
        end
        chk(sram_dq_oe, "R8 data driven in pulse", sram_dq_oe, 1);
        if (!sram_be_n[0]) w[7:0]  = sram_dq_o[7:0];
        if (!sram_be_n[1]) w[15:8] = sram_dq_o[15:8];
        mdl_mem[int'(sram_addr)] = w;
        we_run++;
      end else if (p_we_low) begin
        chk(we_run == WP_EXP, "R2 pulse length", we_run, WP_EXP);
        chk(!sram_cs_n, "R2 hold cycle", sram_cs_n, 0);
        we_run = 0;
      end
      // R5 read window
      if (!sram_oe_n) begin
        chk(!sram_cs_n && sram_we_n, "R5 read strobes", {sram_cs_n, sram_we_n}, 2'b01);
        oe_run++;
      end else if (p_oe_low) begin
        chk(oe_run == RD_EXP, "R5 access length", oe_run, RD_EXP);
        oe_run = 0;
      end
      // R9 turnaround
      if (!sram_cs_n && !p_cs_low) begin
        kind = sram_oe_n ? 2 : 1;
        if (last_kind != 0 && last_kind != kind)
          chk(cs_hi_run >= HZ_EXP + 1, "R9 turnaround gap", cs_hi_run, HZ_EXP + 1);
        last_kind = kind;
      end
      cs_hi_run = sram_cs_n ? cs_hi_run + 1 : 0;
      // R7 / R6 scoreboard
      if (rsp_done) begin
        chk(!p_done, "R7 single pulse", p_done, 0);
        chk(sb_q.size() > 0, "R7 unexpected done", sb_q.size(), 1);
        if (sb_q.size() > 0) begin
          it = sb_q.pop_front();
          if (!it.wr) chk(rsp_rdata == it.exp, "R6 read data", rsp_rdata, it.exp);
        end
      end
      // model output: selected lanes from memory, filler elsewhere
      if (!sram_cs_n && !sram_oe_n && sram_we_n)
        model_dq = {sram_be_n[1] ? 8'hEE : w[15:8], sram_be_n[0] ? 8'hEE : w[7:0]};
      else
        model_dq = 16'hEEEE;
    end
    p_we_low = !sram_we_n; p_oe_low = !sram_oe_n; p_cs_low = !sram_cs_n;
    p_done = rsp_done; p_addr = sram_addr; p_dq = sram_dq_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0; model_dq = 16'hEEEE;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk({sram_cs_n, sram_oe_n, sram_we_n, sram_be_n} == 5'b11111, "R1 strobes",
        {sram_cs_n, sram_oe_n, sram_we_n, sram_be_n}, 5'b11111);
    chk(!sram_dq_oe && req_ready && !rsp_done, "R1 handshake",
        {sram_dq_oe, req_ready, rsp_done}, 3'b010);
    mon_on = 1'b1;

    issue(1, 18'h00010, 16'h1234, 2'b11);
    issue(1, 18'h3FFFF, 16'hBEEF, 2'b11);
    issue(1, 18'h00000, 16'hC0DE, 2'b11);
    issue(0, 18'h00010, 16'h0, 2'b11);
    issue(0, 18'h3FFFF, 16'h0, 2'b11);
    issue(0, 18'h00000, 16'h0, 2'b11);
    issue(0, 18'h02A55, 16'h0, 2'b11);
    // R4 partial lanes and empty write
    issue(1, 18'h00010, 16'hAA77, 2'b01);
    issue(0, 18'h00010, 16'h0, 2'b11);
    issue(1, 18'h00010, 16'h99BB, 2'b10);
    issue(1, 18'h00000, 16'hFFFF, 2'b00);
    issue(0, 18'h00000, 16'h0, 2'b11);
    // R6 masked reads
    issue(0, 18'h00010, 16'h0, 2'b01);
    issue(0, 18'h00010, 16'h0, 2'b10);
    issue(0, 18'h00010, 16'h0, 2'b00);
    // R9 alternating direction, back to back
    for (int i = 0; i < 6; i++) begin
      issue(1, 18'(18'h00100 + i), 16'(16'h3300 + i * 16'h0101), 2'b11);
      issue(0, 18'(18'h00100 + i), 16'h0, 2'b11);
    end
    repeat (20) @(negedge clk);
    // R7 every request answered
    chk(sb_q.size() == 0, "R7 all done", sb_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule